// File: doc/BRIEF.md
# Dual Wrapping SRAM Buffer Port

This block is the serial-command front end for a pair of 264-byte staging buffers in a serial flash controller. A host selects the block with an active-low chip select and clocks in an 8-bit command, a 24-bit header and then data. Bits travel most significant first. The block only recognises buffer load and buffer read commands. A load stores each complete incoming byte at a byte pointer. A read streams stored bytes back out on the serial output. In both cases the pointer steps by one after every byte and returns to byte 0 after the last byte, 263.

The block runs on a system clock that is much faster than the serial clock. It resynchronises chip select, serial clock and serial input, and it finds the serial clock edges inside the system clock domain. A background array engine outside this block can claim one of the two buffers through the `busy` and `busy_buf` inputs. While a buffer is claimed, a command aimed at it is refused as a whole. The other buffer keeps working as usual.

The controller is an explicit state machine:
- IDLE is the state while the block is deselected.
- OPCODE collects the 8 command bits. On the last command bit it moves to IGNORE if the command is unknown or its buffer is claimed. Otherwise it moves to PAD.
- PAD skips the 15 filler bits and then moves to ADDR.
- ADDR collects the 9 pointer bits. It moves to WDATA for a load and to DUMMY for a read.
- DUMMY skips 8 more bits and then moves to RDATA.
- WDATA stores bytes and RDATA returns bytes until chip select rises.
- IGNORE waits silently until chip select rises.
- Every state returns to IDLE when chip select rises.

Top module: `dbuf_spi_port`

## Requirements
- R1: Command byte 84h loads buffer 0 and 87h loads buffer 1. After the 24-bit header, each complete group of 8 bits is stored at the pointer, and the pointer then advances.
- R2: Command bytes 54h and D4h read buffer 0, and 56h and D6h read buffer 1. Each output byte equals the byte stored at the current pointer, and the pointer then advances.
- R3: The header is 15 ignored bits followed by the 9-bit start pointer, most significant bit first. A read adds 8 more ignored bits before data. Input is sampled on rising serial clock edges and output changes on falling edges. `miso_oe` stays low until the first data bit.
- R4: After byte 263 the pointer goes to byte 0, for both loads and reads.
- R5: A start pointer of 264 or above selects byte 0.
- R6: If chip select rises in the middle of a byte, those bits are dropped. Earlier complete bytes stay stored.
- R7: While `busy` is high, any load or read whose buffer equals `busy_buf` (0 or 1) stores nothing, and `miso_oe` stays low for the whole command.
- R8: While one buffer is claimed, loads and reads of the other buffer behave exactly as in R1 and R2.
- R9: `miso_oe` and `miso` are low after reset, while deselected, and during every load command.
- R10: Any other command byte is ignored until chip select rises. No byte is stored and `miso_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idle low or idle high |
| mosi | input | 1 | Serial data into the block |
| busy | input | 1 | An array operation currently claims a buffer |
| busy_buf | input | 1 | Index of the claimed buffer |
| miso | output | 1 | Serial data out of the block, 0 when not driven |
| miso_oe | output | 1 | Output enable for the serial data pad |

## Verification
The bench uses the default build: 264-byte buffers, 15 filler bits and 8 read dummy bits. It runs the serial clock at twelve system clocks per bit. With those sizes, the odd wrap point after byte 263 and the out-of-range pointers from 264 to 511 can be reached within a few bytes. Both clock idle levels are exercised. Random loads and reads with random claims of one buffer are mixed with directed cases: wrap, pointer clamp, a cut-off last byte, claimed-buffer refusal and unknown commands. A byte-level model in the bench predicts every output byte.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int NUM_BUFS = 2;

    localparam logic [7:0] OP_LOAD_B0   = 8'h84;
    localparam logic [7:0] OP_LOAD_B1   = 8'h87;
    localparam logic [7:0] OP_READ_B0_A = 8'h54;
    localparam logic [7:0] OP_READ_B0_B = 8'hD4;
    localparam logic [7:0] OP_READ_B1_A = 8'h56;
    localparam logic [7:0] OP_READ_B1_B = 8'hD6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_PAD,
        ST_ADDR,
        ST_DUMMY,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } port_state_e;

    typedef struct packed {
        logic known;
        logic is_read;
        logic sel;
    } cmd_info_t;

    function automatic cmd_info_t decode_cmd(input logic [7:0] op);
        cmd_info_t c;
        c = '0;
        case (op)
            OP_LOAD_B0:                 c = '{known: 1'b1, is_read: 1'b0, sel: 1'b0};
            OP_LOAD_B1:                 c = '{known: 1'b1, is_read: 1'b0, sel: 1'b1};
            OP_READ_B0_A, OP_READ_B0_B: c = '{known: 1'b1, is_read: 1'b1, sel: 1'b0};
            OP_READ_B1_A, OP_READ_B1_B: c = '{known: 1'b1, is_read: 1'b1, sel: 1'b1};
            default:                    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic sel_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [1:0] cs_q;
    logic [2:0] sck_q;
    logic [1:0] si_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 2'b11;
            sck_q <= 3'b000;
            si_q  <= 2'b00;
        end else begin
            cs_q  <= {cs_q[0], cs_n};
            sck_q <= {sck_q[1:0], sck};
            si_q  <= {si_q[0], mosi};
        end
    end

    assign sel_act  = ~cs_q[1];
    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];
    assign si_s     = si_q[1];

endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
    parameter int BUF_BYTES = 264,
    parameter int NBUF      = 2,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int SEL_W    = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [AW-1:0]    waddr,
    input  logic [7:0]       wdata,
    input  logic [SEL_W-1:0] rsel,
    input  logic [AW-1:0]    raddr,
    output logic [7:0]       rdata
);
    logic [7:0] bank_q [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        logic [7:0] cells [BUF_BYTES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < BUF_BYTES; i++) begin
                    cells[i] <= '0;
                end
            end else if (we && (wsel == SEL_W'(g))) begin
                cells[waddr] <= wdata;
            end
        end

        assign bank_q[g] = cells[raddr];
    end

    assign rdata = bank_q[rsel];

endmodule

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
    import dbuf_pkg::*;
#(
    parameter int BUF_BYTES  = 264,
    parameter int PAD_BITS   = 15,
    parameter int DUMMY_BITS = 8,
    localparam int AW        = $clog2(BUF_BYTES),
    localparam int SH_W      = (AW - 1 > 8) ? AW - 1 : 8,
    localparam int MAXB      = (PAD_BITS > DUMMY_BITS) ?
                               ((PAD_BITS > AW) ? PAD_BITS : AW) :
                               ((DUMMY_BITS > AW) ? DUMMY_BITS : AW),
    localparam int CNT_W     = $clog2(MAXB + 1),
    localparam logic [AW-1:0] LAST = AW'(BUF_BYTES - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          si_s,
    input  logic          busy,
    input  logic          busy_buf,
    input  logic [7:0]    rd_byte,
    output logic          we,
    output logic          wsel,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output logic          rsel,
    output logic [AW-1:0] raddr,
    output logic          miso,
    output logic          miso_oe
);
    port_state_e state, state_d;

    logic [CNT_W-1:0] bitcnt, lim;
    logic [SH_W-1:0]  shreg;
    logic [AW-1:0]    addr;
    logic [2:0]       ocnt;
    logic             miso_q;
    logic             cmd_rd, cmd_sel;
    logic             bit_last;
    logic [7:0]       cur_byte;
    logic [AW-1:0]    addr_word;
    cmd_info_t        dec;
    logic             dec_locked;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_clamp(input logic [AW-1:0] p);
        return (p > LAST) ? '0 : p;
    endfunction

    assign cur_byte   = {shreg[6:0], si_s};
    assign addr_word  = {shreg[AW-2:0], si_s};
    assign dec        = decode_cmd(cur_byte);
    assign dec_locked = busy && (busy_buf == dec.sel);

    // bit limit of the current field
    always_comb begin
        lim = '0;
        unique case (state)
            ST_OPCODE: lim = CNT_W'(7);
            ST_PAD:    lim = CNT_W'(PAD_BITS - 1);
            ST_ADDR:   lim = CNT_W'(AW - 1);
            ST_DUMMY:  lim = CNT_W'(DUMMY_BITS - 1);
            ST_WDATA:  lim = CNT_W'(7);
            ST_IDLE, ST_RDATA, ST_IGNORE: lim = '0;
        endcase
    end
    assign bit_last = (bitcnt == lim);

    // next-state logic
    always_comb begin
        state_d = state;
        if (!sel_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (sck_rise && bit_last)
                               state_d = (!dec.known || dec_locked) ? ST_IGNORE : ST_PAD;
                ST_PAD:    if (sck_rise && bit_last) state_d = ST_ADDR;
                ST_ADDR:   if (sck_rise && bit_last)
                               state_d = cmd_rd ? ST_DUMMY : ST_WDATA;
                ST_DUMMY:  if (sck_rise && bit_last) state_d = ST_RDATA;
                ST_WDATA, ST_RDATA, ST_IGNORE: state_d = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            addr    <= '0;
            ocnt    <= '0;
            miso_q  <= 1'b0;
            cmd_rd  <= 1'b0;
            cmd_sel <= 1'b0;
        end else if (!sel_act) begin
            bitcnt <= '0;
            ocnt   <= '0;
            miso_q <= 1'b0;
        end else begin
            if (sck_rise) begin
                shreg  <= {shreg[SH_W-2:0], si_s};
                bitcnt <= bit_last ? '0 : bitcnt + 1'b1;
                if (state == ST_OPCODE && bit_last) begin
                    cmd_rd  <= dec.is_read;
                    cmd_sel <= dec.sel;
                end
                if (state == ST_ADDR && bit_last)  addr <= ptr_clamp(addr_word);
                if (state == ST_WDATA && bit_last) addr <= ptr_step(addr);
            end
            if (sck_fall && state == ST_RDATA) begin
                miso_q <= rd_byte[3'd7 - ocnt];
                ocnt   <= ocnt + 1'b1;
                if (ocnt == 3'd7) addr <= ptr_step(addr);
            end
        end
    end

    // outputs
    always_comb begin
        we      = (state == ST_WDATA) && sck_rise && bit_last
                  && !(busy && (busy_buf == cmd_sel));
        wsel    = cmd_sel;
        waddr   = addr;
        wdata   = cur_byte;
        rsel    = cmd_sel;
        raddr   = addr;
        miso_oe = (state == ST_RDATA);
        miso    = miso_oe & miso_q;
    end

    a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST);

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == LAST) |=> (addr == '0));

    a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> !miso_oe);

    a_r3_output_after_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> ($past(state) == ST_DUMMY));

    a_r10_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!we && !miso_oe));

endmodule

// File: rtl/dbuf_spi_port.sv
module dbuf_spi_port #(
    parameter int BUF_BYTES  = 264,
    parameter int PAD_BITS   = 15,
    parameter int DUMMY_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic busy,
    input  logic busy_buf,
    output logic miso,
    output logic miso_oe
);
    localparam int AW = $clog2(BUF_BYTES);

    logic          sel_act, sck_rise, sck_fall, si_s;
    logic          we, wsel, rsel;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    wdata, rd_byte;

    dbuf_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .sel_act  (sel_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    dbuf_ctrl #(
        .BUF_BYTES  (BUF_BYTES),
        .PAD_BITS   (PAD_BITS),
        .DUMMY_BITS (DUMMY_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_act  (sel_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s),
        .busy     (busy),
        .busy_buf (busy_buf),
        .rd_byte  (rd_byte),
        .we       (we),
        .wsel     (wsel),
        .waddr    (waddr),
        .wdata    (wdata),
        .rsel     (rsel),
        .raddr    (raddr),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );

    dbuf_store #(
        .BUF_BYTES (BUF_BYTES),
        .NBUF      (dbuf_pkg::NUM_BUFS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wsel  (wsel),
        .waddr (waddr),
        .wdata (wdata),
        .rsel  (rsel),
        .raddr (raddr),
        .rdata (rd_byte)
    );

    a_r7_claimed_buffer_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !(busy && (busy_buf == wsel)));

endmodule

// File: tb/dbuf_spi_port_tb.sv
module dbuf_spi_port_tb;
    localparam int HALF  = 6;
    localparam int NB    = 264;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0, busy_buf = 1'b0;
    logic miso, miso_oe;

    int   n_checks = 0, n_errors = 0;
    logic done = 1'b0;
    logic oe_seen;
    logic [7:0] model [2][NB];

    always #5 clk = ~clk;

    dbuf_spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .busy(busy), .busy_buf(busy_buf), .miso(miso), .miso_oe(miso_oe)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int start_ptr(input logic [8:0] a);
        return (a >= 9'(NB)) ? 0 : int'(a);
    endfunction

    function automatic int next_ptr(input int p);
        return (p == NB - 1) ? 0 : p + 1;
    endfunction

    task automatic bit_x(input logic b, output logic r);
        @(negedge clk);
        sck = 1'b0; mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        if (miso_oe) oe_seen = 1'b1;
        sck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
    endtask

    task automatic begin_cmd(input logic m3);
        @(negedge clk);
        sck = m3;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b0;
        oe_seen = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_cmd(input logic m3);
        repeat (HALF) @(negedge clk);
        if (!m3) sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [8:0] a);
        logic [23:0] hdr;
        logic [7:0]  rx;
        hdr = {15'($urandom), a};
        xfer(hdr[23:16], rx);
        xfer(hdr[15:8], rx);
        xfer(hdr[7:0], rx);
    endtask

    task automatic do_write(input int b, input logic [8:0] a, input int n,
                            input int partial, input logic m3, input string req);
        logic [7:0] rx, d;
        logic       r;
        logic       locked;
        int         p;
        locked = busy && (busy_buf == b[0]);
        begin_cmd(m3);
        xfer((b == 0) ? 8'h84 : 8'h87, rx);
        send_hdr(a);
        p = start_ptr(a);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            xfer(d, rx);
            if (!locked) model[b][p] = d;
            p = next_ptr(p);
        end
        for (int i = 0; i < partial; i++) bit_x(1'($urandom), r);
        end_cmd(m3);
        check(!oe_seen, {req, " R9 no output during load"}, int'(oe_seen), 0);
    endtask

    task automatic do_read(input int b, input logic [8:0] a, input int n,
                           input logic alt, input logic m3, input string req);
        logic [7:0] op, rx;
        logic       locked;
        int         p;
        op = (b == 0) ? (alt ? 8'hD4 : 8'h54) : (alt ? 8'hD6 : 8'h56);
        locked = busy && (busy_buf == b[0]);
        begin_cmd(m3);
        xfer(op, rx);
        send_hdr(a);
        xfer(8'($urandom), rx);
        check(!oe_seen, "R3 no output before data phase", int'(oe_seen), 0);
        p = start_ptr(a);
        for (int i = 0; i < n; i++) begin
            xfer(8'($urandom), rx);
            if (!locked) check(rx == model[b][p], req, int'(rx), int'(model[b][p]));
            p = next_ptr(p);
        end
        end_cmd(m3);
        if (locked) check(!oe_seen, "R7 claimed buffer read stays quiet", int'(oe_seen), 0);
        else        check(oe_seen, {req, " output enabled in data phase"}, int'(oe_seen), 1);
    endtask

    task automatic raw_cmd(input logic [7:0] op, input int nbytes);
        logic [7:0] rx;
        begin_cmd(1'b0);
        xfer(op, rx);
        for (int i = 0; i < nbytes; i++) xfer(8'($urandom), rx);
        end_cmd(1'b0);
        check(!oe_seen, "R10 unknown command quiet", int'(oe_seen), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < NB; i++) model[b][i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!miso_oe, "R9 reset oe", int'(miso_oe), 0);
        check(!miso, "R9 reset miso", int'(miso), 0);

        // basic load and read, both buffers, both clock idle levels
        do_write(0, 9'd5, 4, 0, 1'b0, "R1 load buf0");
        do_write(1, 9'd5, 4, 0, 1'b1, "R1 load buf1");
        do_read(0, 9'd5, 4, 1'b0, 1'b0, "R2 read buf0 54h");
        do_read(0, 9'd4, 6, 1'b1, 1'b1, "R2 read buf0 D4h");
        do_read(1, 9'd5, 4, 1'b0, 1'b1, "R2 read buf1 56h");
        do_read(1, 9'd6, 3, 1'b1, 1'b0, "R3 read buf1 D6h offset");

        // wrap past 263
        do_write(0, 9'd261, 6, 0, 1'b0, "R4 load wrap");
        do_read(0, 9'd262, 5, 1'b0, 1'b0, "R4 read wrap");
        do_read(1, 9'd263, 3, 1'b1, 1'b0, "R4 read wrap buf1");

        // out-of-range start pointer
        do_write(1, 9'd300, 2, 0, 1'b0, "R5 load clamp");
        do_read(1, 9'd0, 2, 1'b0, 1'b0, "R5 readback at 0");
        do_read(1, 9'd511, 3, 1'b0, 1'b1, "R5 read clamp 511");

        // partial final byte
        do_write(0, 9'd20, 2, 5, 1'b0, "R6 load with cut byte");
        do_read(0, 9'd20, 3, 1'b0, 1'b0, "R6 cut byte dropped");

        // claimed buffer refusal, other buffer usable
        busy = 1'b1; busy_buf = 1'b0;
        do_write(0, 9'd30, 3, 0, 1'b0, "R7 load claimed");
        do_read(0, 9'd30, 3, 1'b0, 1'b0, "R7 read claimed");
        do_write(1, 9'd30, 3, 0, 1'b0, "R8 load free buf");
        do_read(1, 9'd30, 3, 1'b1, 1'b0, "R8 read free buf");
        busy = 1'b0;
        do_read(0, 9'd30, 3, 1'b0, 1'b0, "R7 claimed buffer unchanged");

        // unknown commands
        raw_cmd(8'h85, 6);
        raw_cmd(8'h57, 3);
        do_read(0, 9'd0, 8, 1'b0, 1'b0, "R10 buf0 unchanged");
        do_read(1, 9'd0, 8, 1'b0, 1'b0, "R10 buf1 unchanged");

        // constrained random mix
        for (int t = 0; t < 24; t++) begin
            int          b, n;
            logic [8:0]  a;
            busy     = ($urandom % 4) == 0;
            busy_buf = 1'($urandom);
            b = int'($urandom % 2);
            a = ($urandom % 3 == 0) ? 9'(250 + $urandom % 30) : 9'($urandom);
            n = 1 + int'($urandom % 6);
            if ($urandom % 2 == 0)
                do_write(b, a, n, int'($urandom % 8), 1'($urandom), "R1 random load");
            else
                do_read(b, a, n, 1'($urandom), 1'($urandom), "R2 random read");
            busy = 1'b0;
        end
        for (int b = 0; b < 2; b++) do_read(b, 9'd250, 20, 1'b0, 1'b0, "R4 final sweep");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule